// File: doc/BRIEF.md
# SPI Serial Clock Rate Divider

This block derives the serial clock timing of an SPI controller from its module clock. A single rate register holds a mode bit and two divisor fields. With the mode bit clear, the module clock is divided by a power of two picked by a 4-bit exponent. With the mode bit set, it is divided by an even number taken from an 8-bit field. Whichever ratio is picked, it is never below 2.

While the shift engine holds `xfer_active` high, the block issues a one-cycle `half_tick` at every boundary between serial clock half-periods. It also drives a 50% duty `sclk_raw` that toggles on each tick. When `xfer_active` drops, the counter and `sclk_raw` return to their idle state. A new value can be written to the rate register only while no transfer is active, so a rate change never lands in the middle of a period.

Top module: `spi_rate_div`

## Requirements
- R1: After reset, `rate_q` is 0, `half_tick` is 0 and `sclk_raw` is 0.
- R2: With `rate_q[12]`=0 and exponent `rate_q[11:8]`=E with E≥1, the division is 2^E and `half_tick` pulses once every 2^(E-1) module clocks.
- R3: With `rate_q[12]`=0 and E=0, the division is clamped to 2, so `half_tick` pulses on every module clock.
- R4: With `rate_q[12]`=1 and field `rate_q[7:0]`=N, the division is 2·(N+1), so `half_tick` pulses once every N+1 module clocks (every clock for N=0).
- R5: `sclk_raw` toggles in the cycle after each `half_tick` and otherwise holds, which gives 50% duty.
- R6: A write (`rate_we`=1) while `xfer_active`=1 is ignored: `rate_q` and the tick spacing stay unchanged.
- R7: A write while `xfer_active`=0 loads `rate_wdata` into `rate_q`, and it is visible on the next cycle.
- R8: The first `half_tick` of a transfer comes H-1 cycles after the first cycle with `xfer_active` high, where H is the half-period. Once `xfer_active` falls, `sclk_raw` is 0 from the next cycle and the next transfer starts from a fresh count.
- R9: `half_tick` is 0 in every cycle in which `xfer_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_we | input | 1 | Rate register write strobe |
| rate_wdata | input | 13 | Rate value: [12] mode, [11:8] exponent, [7:0] linear field |
| xfer_active | input | 1 | High while the shift engine runs a transfer |
| rate_q | output | 13 | Current rate register contents |
| half_tick | output | 1 | One-cycle pulse at each serial clock half-period boundary |
| sclk_raw | output | 1 | Divided serial clock, low when idle |

## Verification
`half_tick` depends combinationally on the counter and `xfer_active`, so it is valid in the same cycle in which `xfer_active` is driven. The bench drives inputs on the falling edge and samples 1 ns later, calling that cycle 0. It expects ticks at cycles H-1 and 2H-1. `sclk_raw` and `rate_q` are registered, so their effect is checked one cycle after the tick or write that causes it: `sclk_raw` is high in cycle H and low again in cycle 2H. Ignored writes are checked both on `rate_q` and through an unchanged tick spacing.

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rate_we,
  input  logic [EXP_W+LIN_W:0]   rate_wdata,
  input  logic                   xfer_active,
  output logic [EXP_W+LIN_W:0]   rate_q,
  output logic                   half_tick,
  output logic                   sclk_raw
);
  localparam int RW    = EXP_W + LIN_W + 1;
  localparam int EMAX  = (1 << EXP_W) - 1;
  localparam int CW    = (EMAX > LIN_W + 1) ? EMAX : LIN_W + 1;

  logic [CW-1:0]    half_len;
  logic [CW-1:0]    cnt;
  logic [EXP_W-1:0] expo;
  logic [LIN_W-1:0] lin;
  logic             lin_mode;

  assign lin_mode = rate_q[RW-1];
  assign expo     = rate_q[LIN_W +: EXP_W];
  assign lin      = rate_q[LIN_W-1:0];

  always_comb begin
    if (lin_mode)
      half_len = CW'(lin) + CW'(1);
    else if (expo == '0)
      half_len = CW'(1);
    else
      half_len = CW'(1) << (expo - EXP_W'(1));
  end

  assign half_tick = xfer_active && (cnt == half_len - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
    end else if (rate_we && !xfer_active) begin
      rate_q <= rate_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !xfer_active) begin
      cnt      <= '0;
      sclk_raw <= 1'b0;
    end else if (half_tick) begin
      cnt      <= '0;
      sclk_raw <= ~sclk_raw;
    end else begin
      cnt      <= cnt + CW'(1);
    end
  end

  a_r6_write_blocked_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |=> $stable(rate_q));

  a_r7_write_taken_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_we && !xfer_active) |=> (rate_q == $past(rate_wdata)));

  a_r5_sclk_flip: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> (sclk_raw != $past(sclk_raw)));

  a_r5_sclk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !half_tick) |=> $stable(sclk_raw));

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !sclk_raw);

  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> !half_tick);
endmodule

// File: tb/spi_rate_div_test.sv
module spi_rate_div_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_we = 1'b0;
  logic [12:0] rate_wdata = '0;
  logic        xfer_active = 1'b0;
  logic [12:0] rate_q;
  logic        half_tick;
  logic        sclk_raw;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_rate_div uut (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .xfer_active(xfer_active), .rate_q(rate_q), .half_tick(half_tick),
    .sclk_raw(sclk_raw)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_rate(input logic [12:0] v);
    @(negedge clk);
    rate_we = 1'b1;
    rate_wdata = v;
    @(negedge clk);
    rate_we = 1'b0;
    #1;
  endtask

  task automatic run_and_measure(input string req, input int h);
    int first = -1;
    int second = -1;
    int nticks = 0;
    @(negedge clk);
    xfer_active = 1'b1;
    #1;
    for (int i = 0; i <= 2*h; i++) begin
      if (i > 0) begin
        @(negedge clk);
        #1;
      end
      if (half_tick) begin
        nticks++;
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
      if (i == h - 1 && h > 1) check(req, "sclk before first tick", int'(sclk_raw), 0);
      if (i == h) check("R5", "sclk after first tick", int'(sclk_raw), 1);
      if (i == 2*h) check("R5", "sclk after second tick", int'(sclk_raw), 0);
    end
    check(req, "first tick cycle", first, h - 1);
    check(req, "second tick cycle", second, 2*h - 1);
    check(req, "tick count", nticks, (h == 1) ? 2*h + 1 : 2);
    @(negedge clk);
    xfer_active = 1'b0;
    #1;
    check("R9", "tick while idle", int'(half_tick), 0);
    @(negedge clk);
    #1;
    check("R8", "sclk idle low", int'(sclk_raw), 0);
  endtask

  task automatic t_reset;
    check("R1", "rate_q", int'(rate_q), 0);
    check("R1", "half_tick", int'(half_tick), 0);
    check("R1", "sclk_raw", int'(sclk_raw), 0);
  endtask

  task automatic t_pow2;
    write_rate({1'b0, 4'd1, 8'd0});
    check("R7", "rate_q after idle write", int'(rate_q), 13'h0100);
    run_and_measure("R2", 1);
    write_rate({1'b0, 4'd3, 8'd77});
    run_and_measure("R2", 4);
    write_rate({1'b0, 4'd5, 8'd0});
    run_and_measure("R2", 16);
  endtask

  task automatic t_pow2_zero;
    write_rate({1'b0, 4'd0, 8'd200});
    run_and_measure("R3", 1);
  endtask

  task automatic t_linear;
    write_rate({1'b1, 4'd9, 8'd0});
    run_and_measure("R4", 1);
    write_rate({1'b1, 4'd0, 8'd2});
    run_and_measure("R4", 3);
    write_rate({1'b1, 4'd15, 8'd9});
    check("R7", "rate_q linear", int'(rate_q), 13'h1F09);
    run_and_measure("R4", 10);
  endtask

  task automatic t_busy_write;
    int first = -1;
    write_rate({1'b1, 4'd0, 8'd3});
    @(negedge clk);
    xfer_active = 1'b1;
    rate_we = 1'b1;
    rate_wdata = {1'b0, 4'd1, 8'd0};
    #1;
    for (int i = 0; i < 4; i++) begin
      if (i > 0) begin
        @(negedge clk);
        rate_we = 1'b0;
        #1;
      end
      if (half_tick && first < 0) first = i;
    end
    check("R6", "rate_q after busy write", int'(rate_q), 13'h1003);
    check("R6", "tick spacing kept", first, 3);
    @(negedge clk);
    xfer_active = 1'b0;
    #1;
    check("R6", "rate_q still held", int'(rate_q), 13'h1003);
  endtask

  task automatic t_restart;
    write_rate({1'b1, 4'd0, 8'd4});
    @(negedge clk);
    xfer_active = 1'b1;
    repeat (3) @(negedge clk);
    xfer_active = 1'b0;
    @(negedge clk);
    #1;
    check("R8", "sclk low after abort", int'(sclk_raw), 0);
    run_and_measure("R8", 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_pow2();
    t_pow2_zero();
    t_linear();
    t_busy_write();
    t_restart();
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule